// File: doc/BRIEF.md
# Receive Byte Packer with Word FIFO

This block takes bytes from a serial receiver one at a time and assembles them into 32-bit words for a 64-byte receive FIFO, organised as 16 word entries. A word is written only when four bytes are complete, or earlier when the current buffer is closed. A buffer closes on any of four events:

- the line stays quiet for a programmed number of cycles while bytes are pending;
- a byte equal to a programmed character arrives;
- the receiver reports an error;
- software asks for a close.

A close writes a partial word tagged with its valid byte count and an end-of-buffer flag. A close with nothing pending writes nothing.

Software sees four things: the number of bytes held in the packer, a close bit that hardware clears once the close is done, a flush level that empties everything, and a sticky overflow flag. The ready-to-send output either follows the receiver's own request or, in FIFO-control mode, drops once the FIFO is half full.

Top module: `rx_byte_packer`

## Requirements
- R1: Bytes are packed little-endian: the first byte of a word lands in bits 7:0 and the fourth in bits 31:24. The fourth byte completes a word with byte count 4 and end flag 0, unless a close event occurs in the same cycle.
- R2: `pend_cnt_o` reports the bytes held in the packer and not yet written, from 0 to 3. It returns to 0 when a word is formed.
- R3: The FIFO is never written while full. A formed word waits in a stage register and `overflow_o` becomes 1 and stays 1. Bytes arriving during the stall are discarded. The waiting word is written once an entry frees up.
- R4: With at least one byte pending and no new byte for `gap_limit_i` cycles, the pending bytes are written as a partial word. It has byte count 1 to 3, end flag 1, and zero in the unused upper lanes. Every accepted byte restarts the count.
- R5: With `match_en_i` at 1, a byte equal to `match_char_i` is stored and then closes the buffer (end flag 1). With `match_en_i` at 0, that byte does not close the buffer.
- R6: A one-cycle `rx_err_i` pulse closes the buffer and writes the pending bytes with end flag 1.
- R7: A `sw_close_set_i` pulse sets `close_busy_o` in the next cycle. `close_busy_o` returns to 0 when the close has been carried out. A close with no pending bytes writes no entry.
- R8: While `flush_i` is 1:
  - incoming bytes are discarded;
  - `pend_cnt_o` is 0;
  - the FIFO is empty;
  - the stage register, the close bit and `overflow_o` are cleared.
- R9: With `rts_fifo_mode_i` at 1, `rts_o` is 0 when `fifo_level_o` is 8 or more and 1 otherwise. With `rts_fifo_mode_i` at 0, `rts_o` equals `uart_rts_i`.
- R10: The FIFO is first-in first-out and shows its oldest entry on `rd_data_o`, `rd_nbytes_o` and `rd_eob_o`. `rd_en_i` removes that entry at the clock edge. `rd_en_i` on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Flush level; clears the packer and FIFO while 1 |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is on `rx_data_i` |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Receive error pulse; closes the buffer |
| match_en_i | input | 1 | Enables closing on the match character |
| match_char_i | input | 8 | Character that closes the buffer |
| gap_limit_i | input | 16 | Quiet cycles before a gap close (1 or more) |
| sw_close_set_i | input | 1 | Software pulse that sets the close bit |
| close_busy_o | output | 1 | Close bit; cleared by hardware when done |
| pend_cnt_o | output | 2 | Bytes pending in the packer |
| overflow_o | output | 1 | Sticky: a word had to wait on a full FIFO |
| rd_en_i | input | 1 | Pops the oldest FIFO entry |
| rd_data_o | output | 32 | Oldest entry data, first byte in bits 7:0 |
| rd_nbytes_o | output | 3 | Valid bytes in the oldest entry (1..4) |
| rd_eob_o | output | 1 | Oldest entry ends a buffer |
| fifo_empty_o | output | 1 | FIFO holds no entry |
| fifo_level_o | output | 5 | Entries held (0..16) |
| rts_fifo_mode_i | input | 1 | 1: `rts_o` from FIFO fill, 0: from the receiver |
| uart_rts_i | input | 1 | Receiver's own ready-to-send request |
| rts_o | output | 1 | Ready-to-send, 1 = asserted |

## Verification
The packing path is driven in several ways:

- Two back-to-back full words show that lane order and word order are correct.
- A two-byte burst left idle shows that the gap close comes no earlier and no later than the programmed window.
- A non-matching byte followed by the match character separates the enabled match from an ordinary byte.
- A single byte ended by an error pulse, and three bytes ended by a software close, give partial words of one and three lanes.

Filling the FIFO to 16 entries and then sending four more bytes shows the stall: the stalled word must come out last and intact, the extra bytes must vanish, and the overflow flag must stick. Fill levels 7 and 8 check the half-full boundary of the ready-to-send output. Flushing with bytes pending and a word queued shows that neither survives into the next word.

// File: rtl/rxpk_pkg.sv
// Shared widths and the FIFO entry type for the receive byte packer.
// Assumes LANES is a power of two so the pending counter wraps cleanly.
package rxpk_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int CNT_W  = $clog2(LANES);
    localparam int NB_W   = CNT_W + 1;

    // One FIFO entry: packed data, number of valid lanes, end-of-buffer mark.
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [NB_W-1:0]   nbytes;
        logic              eob;
    } rxpk_word_t;
endpackage

// File: rtl/rxpk_gap_timer.sv
// Character-gap timer. Counts quiet cycles while bytes are pending and
// saturates at the limit, so the fire output stays high until the packer
// has actually closed the buffer (this survives a stalled cycle).
// Assumes limit_i >= 1 for a meaningful window.
module rxpk_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_i,
    input  logic             pending_i,
    input  logic [GAP_W-1:0] limit_i,
    output logic             fire_o
);
    logic [GAP_W-1:0] gap_q;

    // Restart on each byte or when idle, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || kick_i || !pending_i) begin
            gap_q <= '0;
        end else if (gap_q != limit_i) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign fire_o = pending_i && (gap_q == limit_i);

    AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && limit_i != '0) |=> !fire_o); // R4
endmodule

// File: rtl/rxpk_fifo.sv
// Synchronous show-ahead FIFO of packed word entries. A write when full
// and a read when empty are ignored. clr_i empties it in one cycle.
// Assumes DEPTH is a power of two.
module rxpk_fifo
    import rxpk_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       wr_i,
    input  rxpk_word_t wr_word_i,
    input  logic       rd_i,
    output rxpk_word_t rd_word_o,
    output logic       empty_o,
    output logic       full_o,
    output logic [LW-1:0] level_o
);
    rxpk_word_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [LW-1:0] level_q;
    logic          do_wr, do_rd;

    assign empty_o = (level_q == '0);
    assign full_o  = (level_q == LW'(DEPTH));
    assign do_wr   = wr_i && !full_o && !clr_i;
    assign do_rd   = rd_i && !empty_o && !clr_i;

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr_q] <= wr_word_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
            if (do_wr && !do_rd)      level_q <= level_q + 1'b1;
            else if (do_rd && !do_wr) level_q <= level_q - 1'b1;
        end
    end

    assign rd_word_o = mem[rd_ptr_q];
    assign level_o   = level_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> !full_o); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o); // R8
endmodule

// File: rtl/rxpk_packer.sv
// Byte packer. Places each accepted byte in the next lane of an
// accumulator. When a word is complete, or a close event arrives with
// bytes pending, it moves the word to a one-entry stage register that
// feeds the FIFO. While the stage cannot drain (FIFO full) the packer
// stalls: incoming bytes are dropped and the sticky overflow flag is set.
module rxpk_packer
    import rxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_err_i,
    input  logic              match_en_i,
    input  logic [BYTE_W-1:0] match_char_i,
    input  logic              sw_close_set_i,
    input  logic              gap_fire_i,
    input  logic              fifo_full_i,
    output logic              take_o,
    output logic              pending_o,
    output logic [CNT_W-1:0]  pend_cnt_o,
    output logic              close_busy_o,
    output logic              overflow_o,
    output logic              push_o,
    output rxpk_word_t        push_word_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q, acc_new;
    rxpk_word_t        stg_q;
    logic              stg_vld_q, close_q, ovf_q;
    logic              stall, take, filled, hit, close_evt, emit, closing;
    logic [NB_W-1:0]   n_new;

    assign stall     = stg_vld_q && fifo_full_i;
    assign take      = rx_valid_i && !flush_i && !stall;
    assign n_new     = NB_W'(cnt_q) + NB_W'(take);
    assign filled    = take && (cnt_q == CNT_W'(LANES - 1));
    assign hit       = take && match_en_i && (rx_data_i == match_char_i);
    assign close_evt = rx_err_i || gap_fire_i || close_q || hit;
    assign closing   = !flush_i && !stall && close_evt;
    assign emit      = !flush_i && !stall && (filled || (close_evt && n_new != '0));

    // Insert the accepted byte in the lane selected by the pending count.
    always_comb begin
        acc_new = acc_q;
        for (int i = 0; i < LANES; i++) begin
            if (take && cnt_q == CNT_W'(i)) acc_new[i*BYTE_W +: BYTE_W] = rx_data_i;
        end
    end

    // Accumulator and pending count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i || emit) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_new;
            cnt_q <= n_new[CNT_W-1:0];
        end
    end

    // Stage register between the accumulator and the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            stg_vld_q <= 1'b0;
            stg_q     <= '0;
        end else if (emit) begin
            stg_vld_q    <= 1'b1;
            stg_q.data   <= acc_new;
            stg_q.nbytes <= filled ? NB_W'(LANES) : n_new;
            stg_q.eob    <= close_evt;
        end else if (push_o) begin
            stg_vld_q <= 1'b0;
        end
    end

    // Software close bit: set by request, cleared once a close is carried out.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i)   close_q <= 1'b0;
        else if (sw_close_set_i) close_q <= 1'b1;
        else if (closing)        close_q <= 1'b0;
    end

    // Sticky overflow flag, raised whenever the stage is blocked by a full FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) ovf_q <= 1'b0;
        else if (stall)        ovf_q <= 1'b1;
    end

    assign push_o       = stg_vld_q && !fifo_full_i && !flush_i;
    assign push_word_o  = stg_q;
    assign take_o       = take;
    assign pending_o    = (cnt_q != '0);
    assign pend_cnt_o   = cnt_q;
    assign close_busy_o = close_q;
    assign overflow_o   = ovf_q;

    AST_CLOSE_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (close_q && !stall && !sw_close_set_i) |=> !close_q); // R7
    AST_PARTIAL_EOB: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld_q && stg_q.nbytes != NB_W'(LANES)) |-> stg_q.eob); // R4
    AST_FLUSH_NOPEND: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0 && !stg_vld_q && !ovf_q)); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush_i) |=> (stg_vld_q && $stable(stg_q))); // R3
endmodule

// File: rtl/rx_byte_packer.sv
// Top of the receive byte packer: packer, gap timer and word FIFO, plus
// the ready-to-send selection. FIFO_BYTES is the FIFO size in bytes and
// must divide into a power-of-two number of word entries.
module rx_byte_packer
    import rxpk_pkg::*;
#(
    parameter int FIFO_BYTES = 64,
    parameter int GAP_W      = 16,
    localparam int DEPTH = FIFO_BYTES / LANES,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_err_i,
    input  logic              match_en_i,
    input  logic [BYTE_W-1:0] match_char_i,
    input  logic [GAP_W-1:0]  gap_limit_i,
    input  logic              sw_close_set_i,
    output logic              close_busy_o,
    output logic [CNT_W-1:0]  pend_cnt_o,
    output logic              overflow_o,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [NB_W-1:0]   rd_nbytes_o,
    output logic              rd_eob_o,
    output logic              fifo_empty_o,
    output logic [LW-1:0]     fifo_level_o,
    input  logic              rts_fifo_mode_i,
    input  logic              uart_rts_i,
    output logic              rts_o
);
    logic       take, pending, gap_fire, fifo_full, push;
    rxpk_word_t push_word, head_word;

    rxpk_packer u_packer (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_i        (flush_i),
        .rx_valid_i     (rx_valid_i),
        .rx_data_i      (rx_data_i),
        .rx_err_i       (rx_err_i),
        .match_en_i     (match_en_i),
        .match_char_i   (match_char_i),
        .sw_close_set_i (sw_close_set_i),
        .gap_fire_i     (gap_fire),
        .fifo_full_i    (fifo_full),
        .take_o         (take),
        .pending_o      (pending),
        .pend_cnt_o     (pend_cnt_o),
        .close_busy_o   (close_busy_o),
        .overflow_o     (overflow_o),
        .push_o         (push),
        .push_word_o    (push_word)
    );

    rxpk_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_i    (take),
        .pending_i (pending),
        .limit_i   (gap_limit_i),
        .fire_o    (gap_fire)
    );

    rxpk_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (flush_i),
        .wr_i      (push),
        .wr_word_i (push_word),
        .rd_i      (rd_en_i),
        .rd_word_o (head_word),
        .empty_o   (fifo_empty_o),
        .full_o    (fifo_full),
        .level_o   (fifo_level_o)
    );

    assign rd_data_o   = head_word.data;
    assign rd_nbytes_o = head_word.nbytes;
    assign rd_eob_o    = head_word.eob;

    // Ready-to-send: receiver-driven, or dropped at half fill in FIFO mode.
    assign rts_o = rts_fifo_mode_i ? (fifo_level_o < LW'(DEPTH / 2)) : uart_rts_i;
endmodule

// File: tb/rx_byte_packer_test.sv
// Directed bench for rx_byte_packer: one task per scenario.
module rx_byte_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0, rx_valid_i = 1'b0, rx_err_i = 1'b0;
    logic [7:0]  rx_data_i = '0, match_char_i = 8'h0A;
    logic        match_en_i = 1'b0, sw_close_set_i = 1'b0, rd_en_i = 1'b0;
    logic [15:0] gap_limit_i = 16'd1000;
    logic        rts_fifo_mode_i = 1'b1, uart_rts_i = 1'b0;
    logic        close_busy_o, overflow_o, rd_eob_o, fifo_empty_o, rts_o;
    logic [1:0]  pend_cnt_o;
    logic [31:0] rd_data_o;
    logic [2:0]  rd_nbytes_o;
    logic [4:0]  fifo_level_o;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    rx_byte_packer uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .rx_valid_i(rx_valid_i),
        .rx_data_i(rx_data_i), .rx_err_i(rx_err_i), .match_en_i(match_en_i),
        .match_char_i(match_char_i), .gap_limit_i(gap_limit_i),
        .sw_close_set_i(sw_close_set_i), .close_busy_o(close_busy_o),
        .pend_cnt_o(pend_cnt_o), .overflow_o(overflow_o), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .rd_nbytes_o(rd_nbytes_o), .rd_eob_o(rd_eob_o),
        .fifo_empty_o(fifo_empty_o), .fifo_level_o(fifo_level_o),
        .rts_fifo_mode_i(rts_fifo_mode_i), .uart_rts_i(uart_rts_i), .rts_o(rts_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_data_i  = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic pop(input string tag, input logic [31:0] d, input int nb, input logic eob);
        @(negedge clk);
        chk({tag, " nonempty"}, 32'(fifo_empty_o), 32'd0);
        chk({tag, " data"}, rd_data_o, d);
        chk({tag, " nbytes"}, 32'(rd_nbytes_o), 32'(nb));
        chk({tag, " eob"}, 32'(rd_eob_o), 32'(eob));
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        cyc(2);
        flush_i = 1'b0;
    endtask

    task automatic t_reset();
        cyc(1);
        chk("R10 reset empty", 32'(fifo_empty_o), 32'd1);
        chk("R2 reset pend", 32'(pend_cnt_o), 32'd0);
        chk("R7 reset busy", 32'(close_busy_o), 32'd0);
        chk("R3 reset ovf", 32'(overflow_o), 32'd0);
        chk("R9 reset rts", 32'(rts_o), 32'd1);
    endtask

    task automatic t_pack();
        send(8'hA1); chk("R2 pend 1", 32'(pend_cnt_o), 32'd1);
        send(8'hB2); send(8'hC3);
        chk("R2 pend 3", 32'(pend_cnt_o), 32'd3);
        send(8'hD4);
        chk("R2 pend back 0", 32'(pend_cnt_o), 32'd0);
        for (int k = 0; k < 4; k++) send(8'h10 + 8'(k));
        cyc(2);
        chk("R10 level 2", 32'(fifo_level_o), 32'd2);
        pop("R1 word0", 32'hD4C3B2A1, 4, 1'b0);
        pop("R1 word1", 32'h13121110, 4, 1'b0);
        chk("R10 empty after pops", 32'(fifo_empty_o), 32'd1);
        @(negedge clk); rd_en_i = 1'b1; @(negedge clk); rd_en_i = 1'b0;
        chk("R10 pop on empty level", 32'(fifo_level_o), 32'd0);
    endtask

    task automatic t_gap();
        gap_limit_i = 16'd20;
        send(8'h11); send(8'h22);
        cyc(10);
        chk("R4 no early close", 32'(fifo_empty_o), 32'd1);
        chk("R4 pend held", 32'(pend_cnt_o), 32'd2);
        cyc(20);
        chk("R4 gap pend 0", 32'(pend_cnt_o), 32'd0);
        pop("R4 gap word", 32'h00002211, 2, 1'b1);
        gap_limit_i = 16'd1000;
    endtask

    task automatic t_match();
        match_en_i = 1'b1;
        send(8'h0B); send(8'h41);
        chk("R5 nonmatch keeps open", 32'(pend_cnt_o), 32'd2);
        send(8'h0A);
        cyc(2);
        pop("R5 match word", 32'h000A410B, 3, 1'b1);
        match_en_i = 1'b0;
        send(8'h0A);
        cyc(2);
        chk("R5 disabled no close", 32'(pend_cnt_o), 32'd1);
        chk("R5 disabled empty", 32'(fifo_empty_o), 32'd1);
        do_flush();
    endtask

    task automatic t_err();
        send(8'h55);
        @(negedge clk); rx_err_i = 1'b1;
        @(negedge clk); rx_err_i = 1'b0;
        cyc(2);
        pop("R6 error word", 32'h00000055, 1, 1'b1);
    endtask

    task automatic t_swclose();
        send(8'h66); send(8'h77); send(8'h88);
        @(negedge clk); sw_close_set_i = 1'b1;
        @(negedge clk); sw_close_set_i = 1'b0;
        chk("R7 busy set", 32'(close_busy_o), 32'd1);
        @(negedge clk);
        chk("R7 busy cleared", 32'(close_busy_o), 32'd0);
        cyc(1);
        pop("R7 close word", 32'h00887766, 3, 1'b1);
        @(negedge clk); sw_close_set_i = 1'b1;
        @(negedge clk); sw_close_set_i = 1'b0;
        cyc(4);
        chk("R7 empty close writes none", 32'(fifo_empty_o), 32'd1);
        chk("R7 empty close busy 0", 32'(close_busy_o), 32'd0);
    endtask

    task automatic t_flush();
        for (int k = 0; k < 4; k++) send(8'h30 + 8'(k));
        send(8'h01); send(8'h02);
        cyc(1);
        chk("R8 setup level", 32'(fifo_level_o), 32'd1);
        @(negedge clk); flush_i = 1'b1;
        send(8'h03);
        chk("R8 pend 0", 32'(pend_cnt_o), 32'd0);
        chk("R8 fifo empty", 32'(fifo_empty_o), 32'd1);
        flush_i = 1'b0;
        for (int k = 0; k < 4; k++) send(8'h40 + 8'(k));
        cyc(2);
        pop("R8 clean word", 32'h43424140, 4, 1'b0);
    endtask

    task automatic t_fill();
        for (int w = 0; w < 16; w++) begin
            for (int k = 0; k < 4; k++) send(8'(w * 4 + k));
            cyc(2);
            if (w == 6) chk("R9 rts at level 7", 32'(rts_o), 32'd1);
            if (w == 7) chk("R9 rts low at level 8", 32'(rts_o), 32'd0);
        end
        chk("R3 level full", 32'(fifo_level_o), 32'd16);
        for (int k = 0; k < 4; k++) send(8'hE0 + 8'(k));
        cyc(1);
        chk("R3 overflow raised", 32'(overflow_o), 32'd1);
        send(8'hF0); send(8'hF1);
        chk("R3 stalled bytes dropped", 32'(pend_cnt_o), 32'd0);
        @(negedge clk); rts_fifo_mode_i = 1'b0; uart_rts_i = 1'b1;
        @(negedge clk);
        chk("R9 direct rts high", 32'(rts_o), 32'd1);
        uart_rts_i = 1'b0;
        @(negedge clk);
        chk("R9 direct rts low", 32'(rts_o), 32'd0);
        rts_fifo_mode_i = 1'b1;
        for (int w = 0; w < 16; w++) begin
            logic [31:0] e;
            e = {8'(w * 4 + 3), 8'(w * 4 + 2), 8'(w * 4 + 1), 8'(w * 4)};
            pop("R3 drain", e, 4, 1'b0);
        end
        pop("R3 stalled word", 32'hE3E2E1E0, 4, 1'b0);
        chk("R3 empty after drain", 32'(fifo_empty_o), 32'd1);
        chk("R3 overflow sticky", 32'(overflow_o), 32'd1);
        do_flush();
        @(negedge clk);
        chk("R8 flush clears overflow", 32'(overflow_o), 32'd0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_pack();
        t_gap();
        t_match();
        t_err();
        t_swclose();
        t_flush();
        t_fill();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule